// File: doc/BRIEF.md
# Transmit Power Index Limiter

This block turns the transmit power levels requested for the current channel into the gain indices written to the transmitter. There is one index for the single-carrier spread-spectrum family (CCK) and one for the multi-carrier family (OFDM). A regulatory ceiling may also be given in dBm. When it is marked usable, the ceiling is converted into an index for each family and bounds the request of that family. A hard cap at 35 then applies to both. The final OFDM index also chooses one of two bias settings for the OFDM gain stage.

The caller presents both levels and the optional ceiling together with a one-cycle strobe. One clock edge later, all three results appear together with a one-cycle valid flag. The results hold their values until the next strobe.

Top module: `txpwr_limiter`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, both indices are 0 and `ofdm_bias` is 0.
- R2: `res_valid` is 1 in exactly the cycle after each cycle where `req_valid` was 1. All three results change on that same edge, and the strobes may arrive back to back.
- R3: When `reg_lim_en` is 0, each index equals its requested level if that level is between 0 and 35. A request above 35 gives 35.
- R4: A negative requested level (two's complement) gives index 0, whether or not a ceiling is applied.
- R5: When `reg_lim_en` is 1, the OFDM ceiling index is 2*`reg_lim_dbm` limited to the range 0..40. The OFDM index is the request reduced to that ceiling when it is larger, then capped at 35.
- R6: When `reg_lim_en` is 1, the CCK ceiling index is 4*`reg_lim_dbm`-52 limited to the range 0..28. The CCK index is the request reduced to that ceiling when it is larger, then capped at 35, so it never exceeds 28 in this case.
- R7: When `reg_lim_en` is 0, the value on `reg_lim_dbm` has no effect on either index.
- R8: With each result, `ofdm_bias` is 2'b01 when the OFDM index is 17 or less and 2'b10 when it is 18 or more. The code 2'b00 appears only after reset.
- R9: In cycles without a strobe, `cck_idx`, `ofdm_idx` and `ofdm_bias` keep their last values, and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Strobe: the request inputs are valid |
| cck_req | input | 8 | Requested CCK level, signed |
| ofdm_req | input | 8 | Requested OFDM level, signed |
| reg_lim_en | input | 1 | Regulatory ceiling is applied |
| reg_lim_dbm | input | 8 | Regulatory ceiling in dBm, signed |
| res_valid | output | 1 | Results were updated on the last edge |
| cck_idx | output | 6 | Final CCK gain index |
| ofdm_idx | output | 6 | Final OFDM gain index |
| ofdm_bias | output | 2 | OFDM gain-stage bias code |

## Verification
The only state in this block is the result register and its valid flag. A fault therefore shows at the ports on the edge that follows the strobe. A wrong conversion slope, offset or range limit gives a wrong index as soon as a ceiling near that boundary is tried. A bad comparison shows as an index above 28 or 35, or as a bias code that does not agree with the index beside it. The stimulus targets the dBm values where a clamp starts or stops. It also checks that the results hold across idle cycles, which catches a register that loads without a strobe.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;
  localparam int LVL_W = 8;
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    BIAS_NONE = 2'd0,
    BIAS_LOW  = 2'd1,
    BIAS_HIGH = 2'd2
  } bias_e;
endpackage

// File: rtl/dbm_to_index.sv
module dbm_to_index #(
  parameter int LVL_W  = 8,
  parameter int IDX_W  = 6,
  parameter int SHIFT  = 1,
  parameter int OFFSET = 0,
  parameter int CEIL   = 40
) (
  input  logic signed [LVL_W-1:0] dbm_i,
  output logic        [IDX_W-1:0] idx_o
);
  localparam int EXT_W = LVL_W + SHIFT + 9;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] scaled;

  always_comb begin
    ext    = {{(EXT_W-LVL_W){dbm_i[LVL_W-1]}}, dbm_i};
    scaled = (ext <<< SHIFT) - $signed(EXT_W'(OFFSET));
    if (scaled < $signed(EXT_W'(0)))
      idx_o = '0;
    else if (scaled > $signed(EXT_W'(CEIL)))
      idx_o = IDX_W'(CEIL);
    else
      idx_o = scaled[IDX_W-1:0];
  end
endmodule

// File: rtl/level_limiter.sv
module level_limiter #(
  parameter int LVL_W = 8,
  parameter int IDX_W = 6,
  parameter int CAP   = 35
) (
  input  logic signed [LVL_W-1:0] level_i,
  input  logic                    lim_en_i,
  input  logic        [IDX_W-1:0] lim_idx_i,
  output logic        [IDX_W-1:0] idx_o
);
  localparam int CMP_W = (LVL_W > IDX_W) ? LVL_W : IDX_W;

  logic [CMP_W-1:0] mag;

  always_comb begin
    if (level_i[LVL_W-1])
      mag = '0;
    else
      mag = CMP_W'(level_i[LVL_W-2:0]);
    if (lim_en_i && (mag > CMP_W'(lim_idx_i)))
      mag = CMP_W'(lim_idx_i);
    if (mag > CMP_W'(CAP))
      mag = CMP_W'(CAP);
    idx_o = mag[IDX_W-1:0];
  end
endmodule

// File: rtl/bias_select.sv
module bias_select #(
  parameter int IDX_W  = 6,
  parameter int THRESH = 17
) (
  input  logic [IDX_W-1:0] idx_i,
  output txpwr_pkg::bias_e code_o
);
  always_comb begin
    if (idx_i <= IDX_W'(THRESH))
      code_o = txpwr_pkg::BIAS_LOW;
    else
      code_o = txpwr_pkg::BIAS_HIGH;
  end
endmodule

// File: rtl/txpwr_limiter.sv
module txpwr_limiter #(
  parameter int LVL_W       = txpwr_pkg::LVL_W,
  parameter int IDX_W       = txpwr_pkg::IDX_W,
  parameter int LEVEL_CAP   = 35,
  parameter int CCK_SHIFT   = 2,
  parameter int CCK_OFFSET  = 52,
  parameter int CCK_CEIL    = 28,
  parameter int OFDM_SHIFT  = 1,
  parameter int OFDM_OFFSET = 0,
  parameter int OFDM_CEIL   = 40,
  parameter int BIAS_THRESH = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] cck_req,
  input  logic [LVL_W-1:0] ofdm_req,
  input  logic             reg_lim_en,
  input  logic [LVL_W-1:0] reg_lim_dbm,
  output logic             res_valid,
  output logic [IDX_W-1:0] cck_idx,
  output logic [IDX_W-1:0] ofdm_idx,
  output logic [1:0]       ofdm_bias
);
  import txpwr_pkg::*;

  localparam int NFAM = 2;  // 0: CCK, 1: OFDM

  logic signed [LVL_W-1:0] fam_req [NFAM];
  logic        [IDX_W-1:0] fam_lim [NFAM];
  logic        [IDX_W-1:0] fam_idx [NFAM];
  bias_e                   bias_next;

  assign fam_req[0] = $signed(cck_req);
  assign fam_req[1] = $signed(ofdm_req);

  for (genvar g = 0; g < NFAM; g++) begin : g_fam
    localparam int SH = (g == 0) ? CCK_SHIFT  : OFDM_SHIFT;
    localparam int OF = (g == 0) ? CCK_OFFSET : OFDM_OFFSET;
    localparam int CE = (g == 0) ? CCK_CEIL   : OFDM_CEIL;

    dbm_to_index #(
      .LVL_W(LVL_W), .IDX_W(IDX_W), .SHIFT(SH), .OFFSET(OF), .CEIL(CE)
    ) u_conv (
      .dbm_i (reg_lim_dbm),
      .idx_o (fam_lim[g])
    );

    level_limiter #(
      .LVL_W(LVL_W), .IDX_W(IDX_W), .CAP(LEVEL_CAP)
    ) u_lim (
      .level_i   (fam_req[g]),
      .lim_en_i  (reg_lim_en),
      .lim_idx_i (fam_lim[g]),
      .idx_o     (fam_idx[g])
    );
  end

  bias_select #(.IDX_W(IDX_W), .THRESH(BIAS_THRESH)) u_bias (
    .idx_i  (fam_idx[1]),
    .code_o (bias_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      cck_idx   <= '0;
      ofdm_idx  <= '0;
      ofdm_bias <= BIAS_NONE;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        cck_idx   <= fam_idx[0];
        ofdm_idx  <= fam_idx[1];
        ofdm_bias <= bias_next;
      end
    end
  end
endmodule

// File: rtl/txpwr_limiter_chk.sv
module txpwr_limiter_chk #(
  parameter int LVL_W = 8,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [LVL_W-1:0] cck_req,
  input logic [LVL_W-1:0] ofdm_req,
  input logic             reg_lim_en,
  input logic [LVL_W-1:0] reg_lim_dbm,
  input logic             res_valid,
  input logic [IDX_W-1:0] cck_idx,
  input logic [IDX_W-1:0] ofdm_idx,
  input logic [1:0]       ofdm_bias
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(cck_idx) && $stable(ofdm_idx) && $stable(ofdm_bias)));

  assert_negative_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cck_req[LVL_W-1]) |=> (cck_idx == '0));

  assert_cck_reg_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && reg_lim_en) |=> (cck_idx <= IDX_W'(28)));

  assert_cap_both_R3: assert property (@(posedge clk) disable iff (rst)
    (cck_idx <= IDX_W'(35)) && (ofdm_idx <= IDX_W'(35)));

  assert_bias_matches_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (ofdm_bias == ((ofdm_idx <= IDX_W'(17)) ? 2'b01 : 2'b10)));
endmodule

bind txpwr_limiter txpwr_limiter_chk #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .cck_req     (cck_req),
  .ofdm_req    (ofdm_req),
  .reg_lim_en  (reg_lim_en),
  .reg_lim_dbm (reg_lim_dbm),
  .res_valid   (res_valid),
  .cck_idx     (cck_idx),
  .ofdm_idx    (ofdm_idx),
  .ofdm_bias   (ofdm_bias)
);

// File: tb/tb_txpwr_limiter.sv
module tb_txpwr_limiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] cck_req = '0;
  logic [7:0] ofdm_req = '0;
  logic       reg_lim_en = 1'b0;
  logic [7:0] reg_lim_dbm = '0;
  logic       res_valid;
  logic [5:0] cck_idx;
  logic [5:0] ofdm_idx;
  logic [1:0] ofdm_bias;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_cck_q[$];
  int    exp_ofdm_q[$];
  int    exp_bias_q[$];
  string tag_q[$];
  int    last_cck = 0, last_ofdm = 0, last_bias = 0;

  always #5 clk = ~clk;

  txpwr_limiter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cck_req(cck_req),
    .ofdm_req(ofdm_req), .reg_lim_en(reg_lim_en), .reg_lim_dbm(reg_lim_dbm),
    .res_valid(res_valid), .cck_idx(cck_idx), .ofdm_idx(ofdm_idx),
    .ofdm_bias(ofdm_bias)
  );

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int c, int o, bit en, int d, string tag);
    int ec, eo;
    @(negedge clk);
    cck_req = 8'(c); ofdm_req = 8'(o); reg_lim_en = en; reg_lim_dbm = 8'(d);
    req_valid = 1'b1;
    ec = (c < 0) ? 0 : c;
    eo = (o < 0) ? 0 : o;
    if (en) begin
      if (ec > clampi(4 * d - 52, 0, 28)) ec = clampi(4 * d - 52, 0, 28);
      if (eo > clampi(2 * d, 0, 40)) eo = clampi(2 * d, 0, 40);
    end
    if (ec > 35) ec = 35;
    if (eo > 35) eo = 35;
    exp_cck_q.push_back(ec);
    exp_ofdm_q.push_back(eo);
    exp_bias_q.push_back((eo <= 17) ? 1 : 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    reg_lim_dbm = 8'h80;
    cck_req = 8'd33; ofdm_req = 8'd33;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever a result is presented
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (exp_cck_q.size() == 0) begin
          check("R2 unexpected result", 1, 0);
        end else begin
          automatic string t = tag_q.pop_front();
          last_cck  = exp_cck_q.pop_front();
          last_ofdm = exp_ofdm_q.pop_front();
          last_bias = exp_bias_q.pop_front();
          check({t, " cck_idx"},   int'(cck_idx),   last_cck);
          check({t, " ofdm_idx"},  int'(ofdm_idx),  last_ofdm);
          check({t, " ofdm_bias R8"}, int'(ofdm_bias), last_bias);
        end
      end else if (exp_cck_q.size() != 0 && !req_valid) begin
        check("R2 missing result", 0, 1);
        void'(tag_q.pop_front()); void'(exp_cck_q.pop_front());
        void'(exp_ofdm_q.pop_front()); void'(exp_bias_q.pop_front());
      end
    end
  end

  task automatic check_hold(string tag);
    check({tag, " R9 res_valid idle"}, int'(res_valid), 0);
    check({tag, " R9 cck hold"},  int'(cck_idx),  last_cck);
    check({tag, " R9 ofdm hold"}, int'(ofdm_idx), last_ofdm);
    check({tag, " R9 bias hold"}, int'(ofdm_bias), last_bias);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 cck_idx", int'(cck_idx), 0);
    check("R1 ofdm_idx", int'(ofdm_idx), 0);
    check("R1 ofdm_bias", int'(ofdm_bias), 0);
    rst = 1'b0;
    idle(2);
    check_hold("after reset");

    drive(10, 20, 0, 0, "R3 plain");
    idle(3);
    check_hold("after plain");
    drive(50, 100, 0, 0, "R3 cap");
    drive(-5, -128, 0, 0, "R4 negative");
    drive(0, 17, 0, 0, "R8 threshold 17");
    drive(35, 18, 0, 0, "R8 threshold 18");
    idle(2);
    drive(20, 34, 1, 15, "R5 R6 limit 15dBm");
    drive(35, 40, 1, 20, "R5 R6 limit 20dBm");
    drive(12, 12, 1, 5, "R6 limit 5dBm");
    drive(12, 12, 1, -3, "R5 limit negative dBm");
    drive(30, 30, 1, 127, "R5 R6 limit max dBm");
    idle(4);
    check_hold("after limits");
    drive(10, 30, 1, 13, "R6 limit 13dBm");
    drive(10, 30, 1, 14, "R6 limit 14dBm");
    drive(3, 9, 1, 15, "R5 below limit");
    drive(-7, -1, 1, 20, "R4 negative limited");
    drive(12, 25, 0, -128, "R7 limit ignored");
    drive(28, 9, 0, 1, "R7 limit ignored 2");
    idle(3);
    check_hold("final");
    check("R2 scoreboard drained", exp_cck_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule